// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream through two register stages. A storage register captures the parallel input word whenever the capture strobe is pulsed. Behind it sits a shift register of the same width. In load mode the shift register copies the storage register on every clock. In shift mode it moves one place toward the serial output on each shift strobe and takes the serial input into its first stage. Because of this serial input, several blocks can be chained: the serial output of one drives the serial input of the next.

Everything runs on one system clock. The two device clocks of a discrete part become single-cycle strobes. The serial output comes out as a data bit plus an active-high drive enable, so a wrapper can build a shared, tri-stated serial line with `assign line = drv ? data : 'z`. The line is driven only in shift mode and only while the output-disable input is low.

Each clock the control decodes exactly one shifter action:
- HOLD: shift mode with no shift strobe. The shifter keeps its value.
- SHIFT: shift mode with a shift strobe. The shifter moves one place.
- FOLLOW: load mode with no capture strobe. The shifter copies the storage register.
- CAPTHRU: load mode with a capture strobe. The new parallel word goes straight into both registers.

Reset moves any action to a cleared state.

Top module: `pisr_latched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the storage register and the shift register to zero, so `ser_data` reads 0 after reset.
- R2: At a clock edge where `cap_stb` is high, the storage register takes `par_in`, whatever the other controls are. Without the strobe it keeps its value.
- R3: While `shift_mode` is 0 (load mode), the shift register takes the storage register value at every clock. No shift strobe is needed, and `shift_stb` has no effect.
- R4: In load mode with `cap_stb` high, the new `par_in` reaches the shift register at the same edge. After that edge, `ser_data` equals `par_in[WIDTH-1]`.
- R5: In shift mode, each clock with `shift_stb` high moves the shift register one place: bit i goes to bit i+1, and `ser_in` enters bit 0. `ser_data` is bit WIDTH-1, so a loaded word leaves MSB first, and serial input bits appear at `ser_data` WIDTH shifts after they enter.
- R6: In shift mode, a clock with `shift_stb` low leaves the shift register unchanged.
- R7: When `cap_stb` and `shift_stb` are high in the same clock in shift mode, the shift uses the old shift-register contents and the storage register takes the new `par_in`.
- R8: `ser_drv` is 1 exactly when `drive_off` is 0 and `shift_mode` is 1. `drive_off` never changes the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel data word |
| cap_stb | input | 1 | Single-cycle strobe that captures `par_in` into storage |
| shift_stb | input | 1 | Single-cycle strobe that shifts the shift register |
| shift_mode | input | 1 | 1 = shift mode, 0 = load mode (level sensitive) |
| ser_in | input | 1 | Serial input into the first stage |
| drive_off | input | 1 | 1 disables the serial output drive |
| ser_data | output | 1 | Last stage of the shift register |
| ser_drv | output | 1 | Drive enable for `ser_data` |

## Verification
One word is loaded and shifted out over eight strobes, which separates an MSB-first order from an LSB-first order and a one-place shift from a stuck or skipped stage. A second serial pattern goes through the register for a further eight strobes. This shows that `ser_in` enters stage 0 and comes out after exactly WIDTH shifts. Capture strobes in load mode, and capture and shift strobes in the same clock in shift mode, distinguish a transparent load from a one-cycle-late load, and an old-data shift from a new-data shift. Toggling `drive_off` across both modes, followed by a long pseudo-random run checked every clock against the queue model, separates the drive-enable term from the data path.

// File: rtl/pisr_pkg.sv
package pisr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_SHIFT   = 2'd1,
        ACT_FOLLOW  = 2'd2,
        ACT_CAPTHRU = 2'd3
    } act_t;

endpackage

// File: rtl/pisr_store.sv
module pisr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] store_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (cap_stb) begin
            store_q <= par_in;
        end
    end

    // R2
    cap_takes_word_chk: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> store_q == $past(par_in));

    // R2
    store_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(store_q));

endmodule

// File: rtl/pisr_ctrl.sv
module pisr_ctrl
    import pisr_pkg::*;
(
    input  logic shift_mode,
    input  logic cap_stb,
    input  logic shift_stb,
    output act_t act
);

    logic [1:0] sel;

    assign sel = {shift_mode, shift_mode ? shift_stb : cap_stb};

    always_comb begin
        unique case (sel)
            2'b00:   act = ACT_FOLLOW;
            2'b01:   act = ACT_CAPTHRU;
            2'b10:   act = ACT_HOLD;
            default: act = ACT_SHIFT;
        endcase
    end

endmodule

// File: rtl/pisr_shifter.sv
module pisr_shifter
    import pisr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  act_t             act,
    input  logic [WIDTH-1:0] store_q,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] sh_q
);

    logic [WIDTH-1:0] sh_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic upstream;
        if (i == 0) begin : g_first
            assign upstream = ser_in;
        end else begin : g_rest
            assign upstream = sh_q[i-1];
        end

        always_comb begin
            unique case (act)
                ACT_FOLLOW:  sh_d[i] = store_q[i];
                ACT_CAPTHRU: sh_d[i] = par_in[i];
                ACT_SHIFT:   sh_d[i] = upstream;
                default:     sh_d[i] = sh_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // R3
    follow_copies_store_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FOLLOW) |=> sh_q == $past(store_q));

    // R5
    shift_one_place_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SHIFT) |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(sh_q));

endmodule

// File: rtl/pisr_latched.sv
module pisr_latched
    import pisr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             cap_stb,
    input  logic             shift_stb,
    input  logic             shift_mode,
    input  logic             ser_in,
    input  logic             drive_off,
    output logic             ser_data,
    output logic             ser_drv
);

    localparam int LAST = WIDTH - 1;

    act_t             act;
    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] sh_q;

    pisr_store #(.WIDTH(WIDTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .cap_stb (cap_stb),
        .par_in  (par_in),
        .store_q (store_q)
    );

    pisr_ctrl ctrl_i (
        .shift_mode (shift_mode),
        .cap_stb    (cap_stb),
        .shift_stb  (shift_stb),
        .act        (act)
    );

    pisr_shifter #(.WIDTH(WIDTH)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .store_q (store_q),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .sh_q    (sh_q)
    );

    assign ser_data = sh_q[LAST];
    assign ser_drv  = shift_mode & ~drive_off;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !ser_data);

    // R4
    capthru_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_mode && cap_stb) |=> ser_data == $past(par_in[LAST]));

    // R7
    both_strobes_old_data_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_mode && cap_stb && shift_stb) |=> ser_data == $past(sh_q[LAST-1]));

    // R8
    drive_gated_chk: assert property (@(posedge clk)
        (drive_off || !shift_mode) |-> !ser_drv);

endmodule

// File: tb/pisr_latched_tb_top.sv
`timescale 1ns/1ps
module pisr_latched_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] par_in;
    logic         cap_stb, shift_stb, shift_mode, ser_in, drive_off;
    logic         ser_data, ser_drv;

    int n_run  = 0;
    int n_fail = 0;

    bit     m_sh[$];
    bit [W-1:0] m_store;

    always #2 clk = ~clk;

    pisr_latched #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .par_in(par_in), .cap_stb(cap_stb),
        .shift_stb(shift_stb), .shift_mode(shift_mode), .ser_in(ser_in),
        .drive_off(drive_off), .ser_data(ser_data), .ser_drv(ser_drv)
    );

    task automatic check(string req, logic act, logic exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic load_model(bit [W-1:0] v);
        for (int i = 0; i < W; i++) m_sh[i] = v[i];
    endtask

    task automatic model_update();
        if (rst) begin
            m_store = '0;
            load_model('0);
        end else begin
            if (!shift_mode) begin
                load_model(cap_stb ? par_in : m_store);
            end else if (shift_stb) begin
                void'(m_sh.pop_back());
                m_sh.push_front(ser_in);
            end
            if (cap_stb) m_store = par_in;
        end
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_update();
        #1;
        check(req, ser_data, m_sh[W-1], "ser_data");
        check("R8", ser_drv, shift_mode & ~drive_off, "ser_drv");
        @(negedge clk);
    endtask

    task automatic idle();
        cap_stb = 0; shift_stb = 0; ser_in = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit [7:0] lfsr;
        bit [W-1:0] word;
        for (int i = 0; i < W; i++) m_sh.push_back(1'b0);
        m_store = '0;
        rst = 1; par_in = 8'hFF; shift_mode = 1; drive_off = 0; idle();
        cap_stb = 1;
        @(negedge clk);
        step("R1");
        rst = 0; idle();
        step("R1");
        check("R1", ser_data, 1'b0, "ser_data after reset");

        // R2 + R6: capture in shift mode leaves shifter alone
        par_in = 8'hA5; cap_stb = 1;
        step("R2");
        idle(); par_in = 8'h00;
        step("R6");
        check("R6", ser_data, 1'b0, "shifter held during capture");

        // R3: load mode follows store, shift strobe ignored
        shift_mode = 0; shift_stb = 1; ser_in = 1;
        step("R3");
        check("R3", ser_data, 1'b1, "follow store MSB of A5");
        check("R8", ser_drv, 1'b0, "no drive in load mode");
        idle();
        step("R3");

        // R5: eight shifts, MSB first
        shift_mode = 1;
        word = 8'hA5;
        for (int k = 0; k < W; k++) begin
            check("R5", ser_data, word[W-1-k], "shift-out order");
            shift_stb = 1; ser_in = k[0];
            step("R5");
        end
        // cascade: serial bits 0,1,0,1.. emerge after W shifts
        for (int k = 0; k < W; k++) begin
            check("R5", ser_data, k[0], "cascade bit");
            shift_stb = 1; ser_in = 1;
            step("R5");
        end
        idle();

        // R4: transparent capture in load mode
        shift_mode = 0; par_in = 8'h80; cap_stb = 1;
        step("R4");
        check("R4", ser_data, 1'b1, "transparent MSB");
        par_in = 8'h3C; cap_stb = 1;
        step("R4");
        check("R4", ser_data, 1'b0, "transparent MSB second word");

        // R7: both strobes in shift mode
        shift_mode = 1; cap_stb = 1; shift_stb = 1; par_in = 8'hFF; ser_in = 0;
        step("R7");
        check("R7", ser_data, 1'b0, "old data shifted (3C bit6)");
        idle();
        step("R7");
        shift_mode = 0;
        step("R7");
        check("R7", ser_data, 1'b1, "store holds new word FF");

        // R8: drive_off toggling in both modes
        for (int k = 0; k < 4; k++) begin
            drive_off = k[0]; shift_mode = k[1];
            step("R8");
            check("R8", ser_drv, k[1] & ~k[0], "drive enable");
        end
        drive_off = 0;

        // pseudo-random run against the model
        lfsr = 8'h5A;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            par_in = lfsr ^ 8'h93;
            cap_stb = lfsr[0]; shift_stb = lfsr[1]; ser_in = lfsr[2];
            shift_mode = lfsr[3] | lfsr[4]; drive_off = lfsr[5] & lfsr[6];
            step("R5");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule